// File: doc/BRIEF.md
# Suspend Mode Pad Control

This block sits between the core of a small 8-bit peripheral controller and its pad ring. In run mode it passes the core's port drivers, host data bus drivers and handshake outputs to the pads unchanged. In suspend mode it forces every pad into a fixed low-leakage state. The only exception is the host data bus buffer, which stays live and follows the host strobes. Each pad gets an output enable, an output value, an input enable and a pull-up enable. An oscillator-enable output tells the clock cell when it may stop.

Inputs that the block disables are also masked on the core side. The core then sees logic 0 from a disabled pad, so a floating pin cannot disturb internal state. The host strobes arrive already converted to active-high levels. All pad and core-side outputs are registered, and the mode is decided on the same clock edge that loads them.

Top module: `susp_pad_ctrl`

## Requirements
- R1: On a clock edge with `susp_req` high, `wake` low and `rst` low, the block enters suspend, and `in_susp` reads 1 after that edge. With both `susp_req` and `wake` low, the mode is held. When `wake` and `susp_req` are both high on the same edge, `wake` wins and the mode becomes run.
- R2: An edge with `rst` high puts the block in run mode, whatever `susp_req` and `wake` are doing. The outputs loaded on that edge carry run-mode values.
- R3: For every port pin in suspend: output enable 0, output value 0, input enable 0, pull-up 0. In run mode the output enable and value follow `prt_oe_i` and `prt_do_i`, and input enable and pull-up are 1.
- R4: In suspend, `dbb_oe_o` equals `pad_cs & pad_rd` and `dbb_ie_o` equals `pad_cs & pad_wr`. In run mode, `dbb_oe_o` follows `dbb_oe_i` and `dbb_ie_o` is 1. In both modes `dbb_do_o` follows `dbb_do_i`.
- R5: The input enables for the strobe pins (`ctl_ie_o`) and for the two test pins (`tst_ie_o`) are 0 in suspend and 1 in run mode.
- R6: In suspend, the external-access pin has input enable 0 and pull-up 0, and the single-step pin has input enable 0 with pull-up 1. In run mode all four of these controls are 1.
- R7: In suspend, `osc_en_o` is 0 and `prog_o` and `sync_o` are 1. In run mode, `osc_en_o` is 1 and `prog_o` and `sync_o` follow `prog_i` and `sync_i`.
- R8: Every core-side input equals its pad value ANDed with that pad's input enable, so a disabled pad reads 0. In suspend, `core_dbb_in` passes the pad data only while `pad_cs & pad_wr` is high.
- R9: Every output is registered. After a given edge it reflects the inputs sampled on that edge and the mode decided on that edge. An edge with `wake` high therefore restores run-mode values on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also a wake source |
| susp_req | input | 1 | Request to enter suspend |
| wake | input | 1 | Wake event, returns to run mode |
| pad_cs | input | 1 | Host chip select pad level (active high) |
| pad_rd | input | 1 | Host read strobe pad level (active high) |
| pad_wr | input | 1 | Host write strobe pad level (active high) |
| pad_a0 | input | 1 | Host address bit 0 pad level |
| pad_t0 | input | 1 | Test input 0 pad level |
| pad_t1 | input | 1 | Test input 1 pad level |
| pad_ea | input | 1 | External-access pad level |
| pad_ss | input | 1 | Single-step pad level |
| prt_oe_i | input | NUM_PORTS*PORT_W | Core port output enables |
| prt_do_i | input | NUM_PORTS*PORT_W | Core port output values |
| prt_pin_i | input | NUM_PORTS*PORT_W | Port pad levels |
| dbb_oe_i | input | 1 | Core data bus output enable (run mode) |
| dbb_do_i | input | DBB_W | Core data bus output value |
| dbb_pin_i | input | DBB_W | Data bus pad levels |
| prog_i | input | 1 | Core value for the expander strobe pin |
| sync_i | input | 1 | Core value for the sync pin |
| in_susp | output | 1 | High while in suspend |
| prt_oe_o | output | NUM_PORTS*PORT_W | Port pad output enables |
| prt_do_o | output | NUM_PORTS*PORT_W | Port pad output values |
| prt_ie_o | output | NUM_PORTS*PORT_W | Port pad input enables |
| prt_pu_o | output | NUM_PORTS*PORT_W | Port pad weak pull-up enables |
| dbb_oe_o | output | 1 | Data bus pad output enable |
| dbb_do_o | output | DBB_W | Data bus pad output values |
| dbb_ie_o | output | 1 | Data bus pad input enable |
| ctl_ie_o | output | 1 | Strobe pin input enable |
| tst_ie_o | output | 1 | Test pin input enable |
| ea_ie_o | output | 1 | External-access input enable |
| ea_pu_o | output | 1 | External-access pull-up enable |
| ss_ie_o | output | 1 | Single-step input enable |
| ss_pu_o | output | 1 | Single-step pull-up enable |
| osc_en_o | output | 1 | Oscillator enable |
| prog_o | output | 1 | Expander strobe pad value |
| sync_o | output | 1 | Sync pad value |
| core_prt_in | output | NUM_PORTS*PORT_W | Gated port levels to the core |
| core_dbb_in | output | DBB_W | Gated data bus levels to the core |
| core_cs | output | 1 | Gated chip select to the core |
| core_rd | output | 1 | Gated read strobe to the core |
| core_wr | output | 1 | Gated write strobe to the core |
| core_a0 | output | 1 | Gated address bit to the core |
| core_t0 | output | 1 | Gated test 0 to the core |
| core_t1 | output | 1 | Gated test 1 to the core |
| core_ea | output | 1 | Gated external-access to the core |
| core_ss | output | 1 | Gated single-step to the core |

## Verification
The bench drives all sixteen combinations of the four host strobes while the block is suspended. A design that decoded the data bus enables from the wrong strobe pair, or that used the gated core-side strobes instead of the pad levels, would open the bus driver on a write or stay silent on a read. It drives `susp_req` and `wake` together on one edge, where a design with the wrong priority would stay suspended. It also checks that the outputs on the very edge that carries `wake` are already in run mode, which exposes a design that spends an extra cycle leaving suspend. Reset is applied while suspended and while `susp_req` is held high, and core-side inputs are driven with random pad data in both modes. These catch a design that ignores reset in suspend, or one that lets a disabled pin leak through as a nonzero core input.

// File: rtl/susp_pkg.sv
package susp_pkg;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_SUSP = 1'b1
  } pad_mode_e;

  // Priority: reset, then wake, then request; otherwise hold.
  function automatic pad_mode_e next_mode(input pad_mode_e cur,
                                          input logic      rst,
                                          input logic      wake,
                                          input logic      req);
    if (rst || wake) return MODE_RUN;
    if (req)         return MODE_SUSP;
    return cur;
  endfunction

endpackage

// File: rtl/susp_mode_fsm.sv
module susp_mode_fsm
  import susp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  logic      wake,
  output pad_mode_e mode_nx,
  output pad_mode_e mode_q
);

  always_comb mode_nx = next_mode(mode_q, rst, wake, req);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RUN;
    else     mode_q <= mode_nx;
  end

endmodule

// File: rtl/susp_port_gate.sv
module susp_port_gate #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          sus,
  input  logic [PW-1:0] oe_i,
  input  logic [PW-1:0] do_i,
  input  logic [PW-1:0] pin_i,
  output logic [PW-1:0] oe_o,
  output logic [PW-1:0] do_o,
  output logic [PW-1:0] ie_o,
  output logic [PW-1:0] pu_o,
  output logic [PW-1:0] core_o
);

  logic [PW-1:0] en_c;

  always_comb en_c = sus ? '0 : '1;

  always_ff @(posedge clk) begin
    oe_o   <= oe_i & en_c;
    do_o   <= do_i & en_c;
    ie_o   <= en_c;
    pu_o   <= en_c;
    core_o <= pin_i & en_c;
  end

endmodule

// File: rtl/susp_dbb_gate.sv
module susp_dbb_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          sus,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic          oe_i,
  input  logic [DW-1:0] do_i,
  input  logic [DW-1:0] pin_i,
  output logic          oe_o,
  output logic [DW-1:0] do_o,
  output logic          ie_o,
  output logic [DW-1:0] core_o
);

  logic oe_c;
  logic ie_c;

  // While suspended the bus buffer is steered by the raw host strobes.
  always_comb begin
    oe_c = sus ? (cs & rd) : oe_i;
    ie_c = sus ? (cs & wr) : 1'b1;
  end

  always_ff @(posedge clk) begin
    oe_o   <= oe_c;
    do_o   <= do_i;
    ie_o   <= ie_c;
    core_o <= pin_i & {DW{ie_c}};
  end

endmodule

// File: rtl/susp_misc_gate.sv
module susp_misc_gate (
  input  logic clk,
  input  logic sus,
  input  logic cs,
  input  logic rd,
  input  logic wr,
  input  logic a0,
  input  logic t0,
  input  logic t1,
  input  logic ea,
  input  logic ss,
  input  logic prog_i,
  input  logic sync_i,
  output logic ctl_ie_o,
  output logic tst_ie_o,
  output logic ea_ie_o,
  output logic ea_pu_o,
  output logic ss_ie_o,
  output logic ss_pu_o,
  output logic osc_en_o,
  output logic prog_o,
  output logic sync_o,
  output logic core_cs,
  output logic core_rd,
  output logic core_wr,
  output logic core_a0,
  output logic core_t0,
  output logic core_t1,
  output logic core_ea,
  output logic core_ss
);

  logic run;

  always_comb run = ~sus;

  always_ff @(posedge clk) begin
    ctl_ie_o <= run;
    tst_ie_o <= run;
    ea_ie_o  <= run;
    ea_pu_o  <= run;
    ss_ie_o  <= run;
    ss_pu_o  <= 1'b1;
    osc_en_o <= run;
    prog_o   <= sus | prog_i;
    sync_o   <= sus | sync_i;
    core_cs  <= cs & run;
    core_rd  <= rd & run;
    core_wr  <= wr & run;
    core_a0  <= a0 & run;
    core_t0  <= t0 & run;
    core_t1  <= t1 & run;
    core_ea  <= ea & run;
    core_ss  <= ss & run;
  end

endmodule

// File: rtl/susp_pad_ctrl.sv
module susp_pad_ctrl
  import susp_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 8,
  parameter int DBB_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        susp_req,
  input  logic                        wake,
  input  logic                        pad_cs,
  input  logic                        pad_rd,
  input  logic                        pad_wr,
  input  logic                        pad_a0,
  input  logic                        pad_t0,
  input  logic                        pad_t1,
  input  logic                        pad_ea,
  input  logic                        pad_ss,
  input  logic [NUM_PORTS*PORT_W-1:0] prt_oe_i,
  input  logic [NUM_PORTS*PORT_W-1:0] prt_do_i,
  input  logic [NUM_PORTS*PORT_W-1:0] prt_pin_i,
  input  logic                        dbb_oe_i,
  input  logic [DBB_W-1:0]            dbb_do_i,
  input  logic [DBB_W-1:0]            dbb_pin_i,
  input  logic                        prog_i,
  input  logic                        sync_i,
  output logic                        in_susp,
  output logic [NUM_PORTS*PORT_W-1:0] prt_oe_o,
  output logic [NUM_PORTS*PORT_W-1:0] prt_do_o,
  output logic [NUM_PORTS*PORT_W-1:0] prt_ie_o,
  output logic [NUM_PORTS*PORT_W-1:0] prt_pu_o,
  output logic                        dbb_oe_o,
  output logic [DBB_W-1:0]            dbb_do_o,
  output logic                        dbb_ie_o,
  output logic                        ctl_ie_o,
  output logic                        tst_ie_o,
  output logic                        ea_ie_o,
  output logic                        ea_pu_o,
  output logic                        ss_ie_o,
  output logic                        ss_pu_o,
  output logic                        osc_en_o,
  output logic                        prog_o,
  output logic                        sync_o,
  output logic [NUM_PORTS*PORT_W-1:0] core_prt_in,
  output logic [DBB_W-1:0]            core_dbb_in,
  output logic                        core_cs,
  output logic                        core_rd,
  output logic                        core_wr,
  output logic                        core_a0,
  output logic                        core_t0,
  output logic                        core_t1,
  output logic                        core_ea,
  output logic                        core_ss
);

  localparam int PB = NUM_PORTS * PORT_W;

  pad_mode_e mode_nx;
  pad_mode_e mode_q;
  logic      sus_nx;

  susp_mode_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (susp_req),
    .wake    (wake),
    .mode_nx (mode_nx),
    .mode_q  (mode_q)
  );

  // Pad controls are loaded from the mode being entered on this edge.
  always_comb sus_nx  = (mode_nx == MODE_SUSP);
  always_comb in_susp = (mode_q == MODE_SUSP);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    susp_port_gate #(.PW(PORT_W)) u_port (
      .clk    (clk),
      .sus    (sus_nx),
      .oe_i   (prt_oe_i[g*PORT_W +: PORT_W]),
      .do_i   (prt_do_i[g*PORT_W +: PORT_W]),
      .pin_i  (prt_pin_i[g*PORT_W +: PORT_W]),
      .oe_o   (prt_oe_o[g*PORT_W +: PORT_W]),
      .do_o   (prt_do_o[g*PORT_W +: PORT_W]),
      .ie_o   (prt_ie_o[g*PORT_W +: PORT_W]),
      .pu_o   (prt_pu_o[g*PORT_W +: PORT_W]),
      .core_o (core_prt_in[g*PORT_W +: PORT_W])
    );
  end

  susp_dbb_gate #(.DW(DBB_W)) u_dbb (
    .clk    (clk),
    .sus    (sus_nx),
    .cs     (pad_cs),
    .rd     (pad_rd),
    .wr     (pad_wr),
    .oe_i   (dbb_oe_i),
    .do_i   (dbb_do_i),
    .pin_i  (dbb_pin_i),
    .oe_o   (dbb_oe_o),
    .do_o   (dbb_do_o),
    .ie_o   (dbb_ie_o),
    .core_o (core_dbb_in)
  );

  susp_misc_gate u_misc (
    .clk      (clk),
    .sus      (sus_nx),
    .cs       (pad_cs),
    .rd       (pad_rd),
    .wr       (pad_wr),
    .a0       (pad_a0),
    .t0       (pad_t0),
    .t1       (pad_t1),
    .ea       (pad_ea),
    .ss       (pad_ss),
    .prog_i   (prog_i),
    .sync_i   (sync_i),
    .ctl_ie_o (ctl_ie_o),
    .tst_ie_o (tst_ie_o),
    .ea_ie_o  (ea_ie_o),
    .ea_pu_o  (ea_pu_o),
    .ss_ie_o  (ss_ie_o),
    .ss_pu_o  (ss_pu_o),
    .osc_en_o (osc_en_o),
    .prog_o   (prog_o),
    .sync_o   (sync_o),
    .core_cs  (core_cs),
    .core_rd  (core_rd),
    .core_wr  (core_wr),
    .core_a0  (core_a0),
    .core_t0  (core_t0),
    .core_t1  (core_t1),
    .core_ea  (core_ea),
    .core_ss  (core_ss)
  );

endmodule

// File: rtl/susp_pad_ctrl_chk.sv
module susp_pad_ctrl_chk #(
  parameter int PB = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          susp_req,
  input logic          wake,
  input logic          pad_cs,
  input logic          pad_rd,
  input logic          pad_wr,
  input logic          in_susp,
  input logic [PB-1:0] prt_oe_o,
  input logic [PB-1:0] prt_ie_o,
  input logic [PB-1:0] prt_pu_o,
  input logic          dbb_oe_o,
  input logic          dbb_ie_o,
  input logic          ctl_ie_o,
  input logic          ea_pu_o,
  input logic          ss_ie_o,
  input logic          ss_pu_o,
  input logic          osc_en_o,
  input logic          prog_o,
  input logic          sync_o,
  input logic          core_cs,
  input logic          core_rd,
  input logic          core_wr,
  input logic          core_a0
);

  logic pv = 1'b0;

  always_ff @(posedge clk) pv <= 1'b1;

  AST_ENTER_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (susp_req && !wake) |=> in_susp); // R1

  AST_RESET_TO_RUN: assert property (@(posedge clk)
    (pv && $past(rst)) |-> !in_susp); // R2

  AST_PORTS_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_susp |-> (prt_oe_o == '0 && prt_ie_o == '0 && prt_pu_o == '0)); // R3

  AST_DBB_READ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (pv && in_susp) |-> (dbb_oe_o == $past(pad_cs && pad_rd))); // R4

  AST_DBB_WRITE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (pv && in_susp) |-> (dbb_ie_o == $past(pad_cs && pad_wr))); // R4

  AST_STROBES_OFF: assert property (@(posedge clk) disable iff (rst)
    in_susp |-> !ctl_ie_o); // R5

  AST_PULLS_SUSP: assert property (@(posedge clk) disable iff (rst)
    in_susp |-> (ss_pu_o && !ss_ie_o && !ea_pu_o)); // R6

  AST_OSC_STOPPED: assert property (@(posedge clk) disable iff (rst)
    in_susp |-> (!osc_en_o && prog_o && sync_o)); // R7

  AST_CORE_STROBES_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_susp |-> !(core_cs || core_rd || core_wr || core_a0)); // R8

  AST_WAKE_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    wake |=> (!in_susp && osc_en_o)); // R9

endmodule

bind susp_pad_ctrl susp_pad_ctrl_chk #(.PB(NUM_PORTS*PORT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .susp_req (susp_req),
  .wake     (wake),
  .pad_cs   (pad_cs),
  .pad_rd   (pad_rd),
  .pad_wr   (pad_wr),
  .in_susp  (in_susp),
  .prt_oe_o (prt_oe_o),
  .prt_ie_o (prt_ie_o),
  .prt_pu_o (prt_pu_o),
  .dbb_oe_o (dbb_oe_o),
  .dbb_ie_o (dbb_ie_o),
  .ctl_ie_o (ctl_ie_o),
  .ea_pu_o  (ea_pu_o),
  .ss_ie_o  (ss_ie_o),
  .ss_pu_o  (ss_pu_o),
  .osc_en_o (osc_en_o),
  .prog_o   (prog_o),
  .sync_o   (sync_o),
  .core_cs  (core_cs),
  .core_rd  (core_rd),
  .core_wr  (core_wr),
  .core_a0  (core_a0)
);

// File: tb/sim_susp_pad_ctrl.sv
module sim_susp_pad_ctrl;

  localparam int NP = 2;
  localparam int PW = 8;
  localparam int DW = 8;
  localparam int PB = NP * PW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          susp_req = 1'b0, wake = 1'b0;
  logic          pad_cs = 1'b0, pad_rd = 1'b0, pad_wr = 1'b0, pad_a0 = 1'b0;
  logic          pad_t0 = 1'b0, pad_t1 = 1'b0, pad_ea = 1'b0, pad_ss = 1'b0;
  logic [PB-1:0] prt_oe_i = '0, prt_do_i = '0, prt_pin_i = '0;
  logic          dbb_oe_i = 1'b0;
  logic [DW-1:0] dbb_do_i = '0, dbb_pin_i = '0;
  logic          prog_i = 1'b0, sync_i = 1'b0;

  logic          in_susp;
  logic [PB-1:0] prt_oe_o, prt_do_o, prt_ie_o, prt_pu_o, core_prt_in;
  logic          dbb_oe_o, dbb_ie_o;
  logic [DW-1:0] dbb_do_o, core_dbb_in;
  logic          ctl_ie_o, tst_ie_o, ea_ie_o, ea_pu_o, ss_ie_o, ss_pu_o;
  logic          osc_en_o, prog_o, sync_o;
  logic          core_cs, core_rd, core_wr, core_a0, core_t0, core_t1, core_ea, core_ss;

  susp_pad_ctrl #(.NUM_PORTS(NP), .PORT_W(PW), .DBB_W(DW)) u0 (.*);

  typedef struct {
    string         ph;
    logic          sus;
    logic [PB-1:0] p_oe, p_do, p_ie, p_pu, p_core;
    logic          d_oe, d_ie;
    logic [DW-1:0] d_do, d_core;
    logic [1:0]    ctl_tst;
    logic [3:0]    ea_ss;
    logic [2:0]    osc_ps;
    logic [7:0]    core_bits;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  logic m_sus  = 1'b0;
  bit   done   = 1'b0;

  task automatic chk(input string rq, input string ph, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s) act=%h exp=%h", rq, ph, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected outputs.
  task automatic step(input logic rq, input logic wk, input logic rs,
                      input logic [3:0] strb, input string ph);
    exp_t e;
    @(negedge clk);
    rst = rs; susp_req = rq; wake = wk;
    {pad_cs, pad_rd, pad_wr, pad_a0} = strb;
    {pad_t0, pad_t1, pad_ea, pad_ss, dbb_oe_i, prog_i, sync_i} = 7'($urandom);
    prt_oe_i = PB'($urandom); prt_do_i = PB'($urandom); prt_pin_i = PB'($urandom);
    dbb_do_i = DW'($urandom); dbb_pin_i = DW'($urandom);
    if (rs || wk) m_sus = 1'b0;
    else if (rq)  m_sus = 1'b1;
    e.ph     = ph;
    e.sus    = m_sus;
    e.p_oe   = m_sus ? '0 : prt_oe_i;
    e.p_do   = m_sus ? '0 : prt_do_i;
    e.p_ie   = m_sus ? '0 : '1;
    e.p_pu   = m_sus ? '0 : '1;
    e.p_core = m_sus ? '0 : prt_pin_i;
    e.d_oe   = m_sus ? (pad_cs & pad_rd) : dbb_oe_i;
    e.d_ie   = m_sus ? (pad_cs & pad_wr) : 1'b1;
    e.d_do   = dbb_do_i;
    e.d_core = e.d_ie ? dbb_pin_i : '0;
    e.ctl_tst = m_sus ? 2'b00 : 2'b11;
    e.ea_ss   = m_sus ? 4'b0001 : 4'b1111;
    e.osc_ps  = m_sus ? 3'b011 : {1'b1, prog_i, sync_i};
    e.core_bits = m_sus ? 8'h00 :
                  {pad_cs, pad_rd, pad_wr, pad_a0, pad_t0, pad_t1, pad_ea, pad_ss};
    q.push_back(e);
  endtask

  // Monitor: compare one edge's outputs against the queued expectation.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R1", e.ph, 128'(in_susp), 128'(e.sus));
        chk("R3", e.ph, 128'({prt_oe_o, prt_do_o, prt_ie_o, prt_pu_o}),
                        128'({e.p_oe, e.p_do, e.p_ie, e.p_pu}));
        chk("R4", e.ph, 128'({dbb_oe_o, dbb_ie_o, dbb_do_o}),
                        128'({e.d_oe, e.d_ie, e.d_do}));
        chk("R5", e.ph, 128'({ctl_ie_o, tst_ie_o}), 128'(e.ctl_tst));
        chk("R6", e.ph, 128'({ea_ie_o, ea_pu_o, ss_ie_o, ss_pu_o}), 128'(e.ea_ss));
        chk("R7", e.ph, 128'({osc_en_o, prog_o, sync_o}), 128'(e.osc_ps));
        chk("R8", e.ph, 128'({core_prt_in, core_dbb_in,
                              core_cs, core_rd, core_wr, core_a0,
                              core_t0, core_t1, core_ea, core_ss}),
                        128'({e.p_core, e.d_core, e.core_bits}));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R2: reset wins over a pending suspend request
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 4'($urandom), "R2");
    // R3: run mode with random traffic
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0, 4'($urandom), "R3");
    // R1: enter suspend
    step(1'b1, 1'b0, 1'b0, 4'b0000, "R1");
    // R4: sweep all strobe combinations while suspended
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 1'b0, 4'(i), "R4");
    // R8: random pad data while suspended
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, 4'($urandom), "R8");
    // R1: wake and request together, wake wins
    step(1'b1, 1'b1, 1'b0, 4'b1100, "R1");
    step(1'b1, 1'b0, 1'b0, 4'b1010, "R1");
    step(1'b0, 1'b0, 1'b0, 4'b1100, "R1");
    // R9: wake restores run values on the same edge
    step(1'b0, 1'b1, 1'b0, 4'b1111, "R9");
    step(1'b0, 1'b0, 1'b0, 4'($urandom), "R9");
    // R2: reset while suspended
    step(1'b1, 1'b0, 1'b0, 4'b1100, "R2");
    step(1'b0, 1'b0, 1'b0, 4'b1010, "R2");
    step(1'b1, 1'b0, 1'b1, 4'b1111, "R2");
    step(1'b0, 1'b0, 1'b0, 4'($urandom), "R2");
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule